// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects a small set of peripheral interrupt request lines and merges them into a single level-sensitive interrupt output for a processor. Software reaches it through a single-cycle register port with address, write data, write enable and combinational read data. A request is first latched into a pending-status register. It then passes a per-source enable mask and a global enable before it can raise the output line.

Each source has its own vector register that holds the start address of its service routine. Alongside the interrupt line, the block presents the vector of the winning source, which is the lowest-numbered source that is both pending and enabled. Capture of request events has a separate arming bit. Once software sets that bit, it stays set until reset. Each source is built as either level-high or rising-edge sensitive through a parameter mask.

Top module: `vic_top`

## Requirements
- R1: After reset, the master, status, enable and vector registers all read zero, and the interrupt output is low.
- R2: Master register bit 0 is the global enable. While it is 0, the interrupt output stays low whatever is pending.
- R3: Master register bit 1 is the capture arm bit, and it resets to 0. While it is 0, no request sets any status bit.
- R4: A write of 0 to the capture arm bit leaves it at 1 once it has been set. Only reset clears it.
- R5: With capture armed, a source whose EDGE_MASK bit is 0 sets its status bit in every cycle its request is high. A source whose EDGE_MASK bit is 1 sets its status bit only in a cycle where its request is high and was low in the previous cycle. The default mask is 4'b1010, so sources 1 and 3 are edge sensitive.
- R6: A status bit is set by its source even while the matching enable-mask bit is 0.
- R7: The interrupt output is high exactly when the global enable is 1 and at least one bit of (status AND enable mask) is 1.
- R8: Writing the acknowledge address clears every status bit whose write-data bit is 1. Bits written 0 are left unchanged.
- R9: When a set event and an acknowledge of the same status bit fall in the same cycle, the bit stays set.
- R10: The vector output carries the vector register of the lowest-numbered source whose status and enable bits are both 1. It carries zero when there is no such source. This does not depend on the global enable.
- R11: Register map by word address: 0 master, 1 status (read-only), 2 enable mask, 3 acknowledge (write-only, reads zero), 4+i vector of source i. Reads return the stored values, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busWe | input | 1 | Write strobe, one write per cycle |
| busRdata | output | DATA_W | Combinational read data for busAddr |
| reqIn | input | NUM_SRC | Peripheral request lines |
| irqOut | output | 1 | Merged interrupt request to the processor |
| irqVector | output | DATA_W | Vector of the winning pending, enabled source |

## Verification
A request capture and a software acknowledge of the same status bit can land in one clock cycle. The bench provokes this in two ways. In the first, it holds all requests high and then acknowledges every bit, so the level sources keep getting set while the edge sources do not. In the second, it raises a fresh edge in the same cycle as a write that acknowledges that bit. The outcome is judged by reading back the status register: bits whose set event coincided with the acknowledge must remain 1, and only the others may clear.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_MASTER = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_ENABLE = 2;
  localparam int ADDR_ACK    = 3;
  localparam int ADDR_VEC0   = 4;

  typedef enum logic [2:0] {
    SEL_MASTER,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_VEC,
    SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic   masterWr;
    logic   enableWr;
    logic   ackWr;
    logic   vecWr;
    rdSel_e rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_SRC = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrlStrb_t         strb
);
  localparam int VEC_END = ADDR_VEC0 + NUM_SRC;

  logic isVec;
  assign isVec = (int'(busAddr) >= ADDR_VEC0) && (int'(busAddr) < VEC_END);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    if (isVec) begin
      strb.vecWr = busWe;
      strb.rdSel = SEL_VEC;
    end else begin
      case (int'(busAddr))
        ADDR_MASTER: begin strb.masterWr = busWe; strb.rdSel = SEL_MASTER; end
        ADDR_STATUS: strb.rdSel = SEL_STATUS;
        ADDR_ENABLE: begin strb.enableWr = busWe; strb.rdSel = SEL_ENABLE; end
        ADDR_ACK:    strb.ackWr = busWe;
        default:     strb.rdSel = SEL_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/vic_dpath.sv
module vic_dpath
  import vic_pkg::*;
#(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 32,
  parameter int                 NUM_SRC   = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic              irqOut,
  output logic [DATA_W-1:0] irqVector
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                globalEn, captureArm;
  logic [NUM_SRC-1:0]  status, enMask, reqPrev, setEvt, ackMask, pend;
  logic [DATA_W-1:0]   vecReg [NUM_SRC];
  logic [ADDR_W-1:0]   vecOff;
  logic [IDX_W-1:0]    wrIdx, winIdx;

  assign vecOff  = busAddr - ADDR_W'(ADDR_VEC0);
  assign wrIdx   = vecOff[IDX_W-1:0];
  assign ackMask = strb.ackWr ? busWdata[NUM_SRC-1:0] : '0;

  // per-source sensitivity chosen by parameter
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (EDGE_MASK[s]) begin : g_edge
      assign setEvt[s] = captureArm & reqIn[s] & ~reqPrev[s];
    end else begin : g_level
      assign setEvt[s] = captureArm & reqIn[s];
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                     vecReg[s] <= '0;
      else if (strb.vecWr && wrIdx == IDX_W'(s))     vecReg[s] <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn   <= 1'b0;
      captureArm <= 1'b0;
      enMask     <= '0;
      status     <= '0;
      reqPrev    <= '0;
    end else begin
      reqPrev <= reqIn;
      status  <= (status & ~ackMask) | setEvt;
      if (strb.masterWr) begin
        globalEn   <= busWdata[0];
        captureArm <= captureArm | busWdata[1];
      end
      if (strb.enableWr) enMask <= busWdata[NUM_SRC-1:0];
    end
  end

  assign pend   = status & enMask;
  assign irqOut = globalEn & (|pend);

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) winIdx = IDX_W'(i);
    end
  end

  assign irqVector = (|pend) ? vecReg[winIdx] : '0;

  always_comb begin
    case (strb.rdSel)
      SEL_MASTER: busRdata = DATA_W'({captureArm, globalEn});
      SEL_STATUS: busRdata = DATA_W'(status);
      SEL_ENABLE: busRdata = DATA_W'(enMask);
      SEL_VEC:    busRdata = vecReg[wrIdx];
      default:    busRdata = '0;
    endcase
  end

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    captureArm |=> captureArm);

  // R3
  no_capture_unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !captureArm |=> ((status & ~$past(status)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setEvt) |=> ((status & $past(setEvt)) == $past(setEvt)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackWr |=> ((status & $past(ackMask & ~setEvt)) == '0));

  // R10
  winner_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|pend) |-> (pend[winIdx] &&
      ((pend & ((NUM_SRC'(1) << winIdx) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int                 ADDR_W    = 4,
  parameter int                 DATA_W    = 32,
  parameter int                 NUM_SRC   = 4,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic               irqOut,
  output logic [DATA_W-1:0]  irqVector
);
  ctrlStrb_t strb;

  vic_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .strb(strb)
  );

  vic_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC),
              .EDGE_MASK(EDGE_MASK)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .reqIn(reqIn),
    .irqOut(irqOut), .irqVector(irqVector)
  );
endmodule

// File: tb/vic_top_bench.sv
module vic_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam logic [3:0] EDGE = 4'b1010;

  logic        clk = 0, rstN = 0, busWe = 0, irqOut;
  logic [3:0]  busAddr = 0, reqIn = 0;
  logic [31:0] busWdata = 0, busRdata, irqVector;
  int checks = 0, bad = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_top u_vic_top (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .reqIn(reqIn), .irqOut(irqOut),
    .irqVector(irqVector));

  function automatic logic [31:0] vecVal(int i);
    return 32'h4000_0010 + 32'(i) * 32'h124;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); busAddr = 4'(a); busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); busAddr = 4'(a); busWe = 0; #1 d = busRdata;
  endtask

  task automatic setStatus(logic [3:0] p);
    @(negedge clk); reqIn = 0;
    wr(3, 32'hF);
    reqIn = p;
    @(negedge clk); reqIn = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(0, d); check("R1", d, 0);
    rd(1, d); check("R1", d, 0);
    rd(2, d); check("R1", d, 0);
    rd(5, d); check("R1", d, 0);
    check("R1", {31'b0, irqOut}, 0);
    // R3 no capture before arming
    @(negedge clk); reqIn = 4'hF;
    @(negedge clk); @(negedge clk); reqIn = 0;
    rd(1, d); check("R3", d, 0);
    // arm, then R4 sticky
    wr(0, 32'h3);
    rd(0, d); check("R4", d, 3);
    wr(0, 32'h0);
    rd(0, d); check("R4", d, 2);
    // R11 vector/enable readback
    for (int i = 0; i < NSRC; i++) wr(4 + i, vecVal(i));
    for (int i = 0; i < NSRC; i++) begin rd(4 + i, d); check("R11", d, vecVal(i)); end
    wr(2, 32'h5); rd(2, d); check("R11", d, 5);
    wr(2, 32'h0);
    // R6 status set while masked; R2 global enable low
    setStatus(4'hF);
    rd(1, d); check("R6", d, 32'hF);
    rd(3, d); check("R11", d, 0);
    // R8 ack of zero has no effect, partial ack clears
    wr(3, 32'h0); rd(1, d); check("R8", d, 32'hF);
    wr(3, 32'h6); rd(1, d); check("R8", d, 32'h9);
    // R5/R9 held requests: level bits re-set during ack, edge bits clear
    @(negedge clk); reqIn = 4'hF;
    @(negedge clk); @(negedge clk);
    wr(3, 32'hF);
    rd(1, d); check("R5", d, 32'(~EDGE & 4'hF));
    reqIn = 0;
    @(negedge clk);
    wr(3, 32'hF);
    rd(1, d); check("R5", d, 0);
    // R9 fresh edge on source 1 together with its acknowledge
    setStatus(4'h2);
    @(negedge clk); reqIn = 0;
    busAddr = 3; busWdata = 32'h2; busWe = 1; reqIn = 4'h2;
    @(negedge clk); busWe = 0; reqIn = 0;
    rd(1, d); check("R9", d, 32'h2);
    // sweep R2/R7/R10 over global enable, status and mask
    for (int g = 0; g < 2; g++) begin
      wr(0, 32'(2 + g));
      for (int p = 0; p < 16; p++) begin
        setStatus(4'(p));
        for (int m = 0; m < 16; m++) begin
          logic [3:0] pe;
          logic [31:0] ev;
          wr(2, 32'(m));
          pe = 4'(p & m);
          ev = 0;
          for (int i = NSRC - 1; i >= 0; i--) if (pe[i]) ev = vecVal(i);
          @(negedge clk); #1;
          check(g == 0 ? "R2" : "R7", {31'b0, irqOut}, {31'b0, (g == 1) && (pe != 0)});
          check("R10", irqVector, ev);
        end
      end
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule